// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block is the mode controller of a supply-and-bus interface chip. It watches digitised supply-monitor flags, an over-temperature flag, the host enable and transmit-data pins and a bus wakeup flag. From these it moves the chip between six operating modes: Shutdown, Reset, Normal, Standby, Sleep and Thermal Shutdown. In each mode it drives the regulator enable, the active-low reset line to the host and a three-way bus mode select.

All timing runs on a one-microsecond tick input. The length of the reset pulse, the host sampling delay, the low-power entry time, the wake-to-Normal time and the undervoltage filter are all parameters counted in ticks. The host asks for low power by pulling the enable pin low. After a fixed sampling delay the block reads the transmit pin: high selects Standby and low selects Sleep. Every way out of Sleep passes through a timed reset pulse.

Top module: `pwr_mode_seq`

## Requirements
- R1: After the block reset, mode_code is 0 (Shutdown), reg_en is 0, rst_out_n is 0 and lin_mode is 0 (Off).
- R2: When sup_below_lo is 1, the next clock edge puts the block in Shutdown (mode 0, regulator off, reset low, LIN Off) from any mode. This takes priority over every other input.
- R3: Shutdown is left only when sup_above_hi is 1 and over_temp is 0. The next mode is always Reset (mode 1).
- R4: In Reset (mode 1), reg_en is 1, rst_out_n is 0 and lin_mode is 1 (Wakeup). Reset is left only when at least RST_US ticks have passed since entry and vout_low is 0. The next mode is Normal (2) if en_pin is 1, otherwise Standby (3).
- R5: In Normal with no low-power request pending, reg_en is 1, rst_out_n is 1 and lin_mode is 2 (Active).
- R6: en_pin low in Normal starts a request. From the next edge lin_mode is 1, which blocks the transmitter. After SAMPLE_US ticks, txd_pin high selects Standby and low selects Sleep. The new mode is taken LP_US ticks after the request started. Sleep (mode 4) is entered only from Normal.
- R7: en_pin returning high before the sample point cancels the request: the block stays in Normal with lin_mode 2.
- R8: In Standby, reg_en is 1, rst_out_n is 1 and lin_mode is 1. en_pin held high for MODE_US ticks moves the block to Normal. Shorter pulses leave it in Standby.
- R9: In Sleep, reg_en is 0, rst_out_n is 0 and lin_mode is 1. wake_det or en_pin high moves the block to Reset.
- R10: In Normal or Standby, vout_low held for UV_US consecutive ticks forces Reset. A shorter dip has no effect.
- R11: over_temp forces Thermal Shutdown (mode 5: reg_en 0, rst_out_n 0, lin_mode 1) from every mode except Shutdown. Once over_temp clears, the next mode is Reset.
- R12: mode_code encodes the mode as Shutdown 0, Reset 1, Normal 2, Standby 3, Sleep 4, Thermal Shutdown 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low block reset |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| sup_above_hi | input | 1 | Supply above the high power-on threshold |
| sup_below_lo | input | 1 | Supply below the low power-on threshold |
| vout_low | input | 1 | Regulator output below its reset threshold |
| over_temp | input | 1 | Junction over-temperature flag |
| en_pin | input | 1 | Host enable pin |
| txd_pin | input | 1 | Host transmit-data pin |
| wake_det | input | 1 | Bus wakeup detected |
| reg_en | output | 1 | Regulator enable |
| rst_out_n | output | 1 | Active-low reset to the host |
| lin_mode | output | 2 | Bus mode: 0 Off, 1 Wakeup, 2 Active |
| mode_code | output | 3 | Current operating mode |

## Verification
Some properties are checked on every cycle by the assertions:
- the Shutdown override and the Thermal Shutdown override;
- that Shutdown is always left to Reset and that Sleep is only ever reached from Normal;
- the output pattern in Reset and in Sleep;
- the forced Reset once the undervoltage filter fires.

Other behaviour can only be shown by the bench's scenarios, because it depends on a count of ticks or on what the host pins did earlier:
- the length of the reset pulse and the undervoltage blocking Reset exit;
- how the TxD sample picks Standby or Sleep;
- a cancelled low-power request;
- a short enable pulse in Standby and a short undervoltage dip, both of which must be ignored.

// File: rtl/pms_pkg.sv
package pms_pkg;

  typedef enum logic [2:0] {
    M_OFF = 3'd0,
    M_RST = 3'd1,
    M_NRM = 3'd2,
    M_STB = 3'd3,
    M_SLP = 3'd4,
    M_HOT = 3'd5
  } pms_mode_e;

  typedef enum logic [1:0] {
    L_OFF  = 2'd0,
    L_WAKE = 2'd1,
    L_ACT  = 2'd2
  } pms_lin_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SAMPLE,
    PH_COMMIT,
    PH_WAKE
  } pms_phase_e;

  // true once a tick count has reached its limit
  function automatic logic elapsed(input int unsigned cnt, input int unsigned lim);
    return cnt >= lim;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pms_tick_counter.sv
module pms_tick_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (tick && cnt != '1) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pms_uv_filter.sv
module pms_uv_filter #(
  parameter int unsigned FILT_US = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic uv_raw,
  output logic uv_hit
);
  import pms_pkg::*;
  localparam int unsigned FW = $clog2(FILT_US + 1);

  logic [FW-1:0] uv_cnt;

  pms_tick_counter #(.W(FW)) i_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!uv_raw),
    .tick  (tick),
    .cnt   (uv_cnt)
  );

  assign uv_hit = uv_raw && elapsed(32'(uv_cnt), FILT_US);
endmodule

// File: rtl/pms_fsm.sv
module pms_fsm #(
  parameter int unsigned TW        = 13,
  parameter int unsigned RST_US    = 5000,
  parameter int unsigned SAMPLE_US = 25,
  parameter int unsigned MODE_US   = 25,
  parameter int unsigned LP_US     = 45
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sup_above_hi,
  input  logic          sup_below_lo,
  input  logic          vout_low,
  input  logic          over_temp,
  input  logic          en_pin,
  input  logic          txd_pin,
  input  logic          wake_det,
  input  logic          uv_hit,
  input  logic [TW-1:0] tmr_cnt,
  output logic          tmr_clr,
  output logic          reg_en,
  output logic          rst_out_n,
  output logic [1:0]    lin_mode,
  output logic [2:0]    mode_code
);
  import pms_pkg::*;

  pms_mode_e  mode_q, mode_d, tgt_q, tgt_d;
  pms_phase_e phase_q, phase_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_OFF;
      phase_q <= PH_IDLE;
      tgt_q   <= M_STB;
    end else begin
      mode_q  <= mode_d;
      phase_q <= phase_d;
      tgt_q   <= tgt_d;
    end
  end

  always_comb begin
    mode_d  = mode_q;
    phase_d = phase_q;
    tgt_d   = tgt_q;
    tmr_clr = 1'b0;
    if (sup_below_lo) begin
      mode_d  = M_OFF;
      phase_d = PH_IDLE;
    end else if (over_temp && mode_q != M_OFF) begin
      mode_d  = M_HOT;
      phase_d = PH_IDLE;
    end else begin
      case (mode_q)
        M_OFF: if (sup_above_hi && !over_temp) begin
          mode_d  = M_RST;
          tmr_clr = 1'b1;
        end
        M_HOT: begin
          mode_d  = M_RST;
          tmr_clr = 1'b1;
        end
        M_RST: if (elapsed(32'(tmr_cnt), RST_US) && !vout_low) begin
          mode_d  = en_pin ? M_NRM : M_STB;
          phase_d = PH_IDLE;
        end
        M_NRM: begin
          if (uv_hit) begin
            mode_d  = M_RST;
            phase_d = PH_IDLE;
            tmr_clr = 1'b1;
          end else begin
            case (phase_q)
              PH_IDLE: if (!en_pin) begin
                phase_d = PH_SAMPLE;
                tmr_clr = 1'b1;
              end
              PH_SAMPLE: begin
                if (en_pin) phase_d = PH_IDLE;
                else if (elapsed(32'(tmr_cnt), SAMPLE_US)) begin
                  tgt_d   = txd_pin ? M_STB : M_SLP;
                  phase_d = PH_COMMIT;
                end
              end
              PH_COMMIT: if (elapsed(32'(tmr_cnt), LP_US)) begin
                mode_d  = tgt_q;
                phase_d = PH_IDLE;
              end
              default: phase_d = PH_IDLE;
            endcase
          end
        end
        M_STB: begin
          if (uv_hit) begin
            mode_d  = M_RST;
            phase_d = PH_IDLE;
            tmr_clr = 1'b1;
          end else if (phase_q == PH_WAKE) begin
            if (!en_pin) phase_d = PH_IDLE;
            else if (elapsed(32'(tmr_cnt), MODE_US)) begin
              mode_d  = M_NRM;
              phase_d = PH_IDLE;
            end
          end else if (en_pin) begin
            phase_d = PH_WAKE;
            tmr_clr = 1'b1;
          end
        end
        M_SLP: if (wake_det || en_pin) begin
          mode_d  = M_RST;
          tmr_clr = 1'b1;
        end
        default: mode_d = M_OFF;
      endcase
    end
  end

  always_comb begin
    reg_en    = 1'b0;
    rst_out_n = 1'b0;
    lin_mode  = L_WAKE;
    case (mode_q)
      M_OFF: lin_mode = L_OFF;
      M_RST: reg_en = 1'b1;
      M_NRM: begin
        reg_en    = 1'b1;
        rst_out_n = 1'b1;
        lin_mode  = (phase_q == PH_IDLE) ? L_ACT : L_WAKE;
      end
      M_STB: begin
        reg_en    = 1'b1;
        rst_out_n = 1'b1;
      end
      default: ;
    endcase
  end

  assign mode_code = mode_q;
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq #(
  parameter int unsigned RST_US    = 5000,
  parameter int unsigned SAMPLE_US = 25,
  parameter int unsigned MODE_US   = 25,
  parameter int unsigned LP_US     = 45,
  parameter int unsigned UV_US     = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic       sup_above_hi,
  input  logic       sup_below_lo,
  input  logic       vout_low,
  input  logic       over_temp,
  input  logic       en_pin,
  input  logic       txd_pin,
  input  logic       wake_det,
  output logic       reg_en,
  output logic       rst_out_n,
  output logic [1:0] lin_mode,
  output logic [2:0] mode_code
);
  import pms_pkg::*;

  localparam int unsigned TMAX = umax(umax(RST_US, SAMPLE_US), umax(MODE_US, LP_US));
  localparam int unsigned TW   = $clog2(TMAX + 1);

  logic          uv_hit;
  logic          tmr_clr;
  logic [TW-1:0] tmr_cnt;

  pms_uv_filter #(.FILT_US(UV_US)) i_uv (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (us_tick),
    .uv_raw (vout_low),
    .uv_hit (uv_hit)
  );

  pms_tick_counter #(.W(TW)) i_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .tick  (us_tick),
    .cnt   (tmr_cnt)
  );

  pms_fsm #(
    .TW(TW), .RST_US(RST_US), .SAMPLE_US(SAMPLE_US),
    .MODE_US(MODE_US), .LP_US(LP_US)
  ) i_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .sup_above_hi (sup_above_hi),
    .sup_below_lo (sup_below_lo),
    .vout_low     (vout_low),
    .over_temp    (over_temp),
    .en_pin       (en_pin),
    .txd_pin      (txd_pin),
    .wake_det     (wake_det),
    .uv_hit       (uv_hit),
    .tmr_cnt      (tmr_cnt),
    .tmr_clr      (tmr_clr),
    .reg_en       (reg_en),
    .rst_out_n    (rst_out_n),
    .lin_mode     (lin_mode),
    .mode_code    (mode_code)
  );
endmodule

// File: rtl/pms_chk.sv
module pms_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sup_below_lo,
  input logic       over_temp,
  input logic       uv_hit,
  input logic       reg_en,
  input logic       rst_out_n,
  input logic [1:0] lin_mode,
  input logic [2:0] mode_code
);
  // R2
  sup_lo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sup_below_lo |=> mode_code == 3'd0);

  // R11
  hot_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sup_below_lo && over_temp && mode_code != 3'd0) |=> mode_code == 3'd5);

  // R3
  off_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_code) == 3'd0 && mode_code != 3'd0) |-> mode_code == 3'd1);

  // R4
  rst_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_code == 3'd1 |-> (reg_en && !rst_out_n && lin_mode == 2'd1));

  // R9
  sleep_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_code == 3'd4 |-> (!reg_en && !rst_out_n && lin_mode == 2'd1));

  // R6
  sleep_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd4 && $past(mode_code) != 3'd4) |-> $past(mode_code) == 3'd2);

  // R10
  uv_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_hit && (mode_code == 3'd2 || mode_code == 3'd3) && !sup_below_lo && !over_temp)
    |=> mode_code == 3'd1);
endmodule

bind pwr_mode_seq pms_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sup_below_lo (sup_below_lo),
  .over_temp    (over_temp),
  .uv_hit       (uv_hit),
  .reg_en       (reg_en),
  .rst_out_n    (rst_out_n),
  .lin_mode     (lin_mode),
  .mode_code    (mode_code)
);

// File: tb/test_pwr_mode_seq.sv
module test_pwr_mode_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       us_tick = 1'b0;
  logic       sup_above_hi = 1'b0, sup_below_lo = 1'b0, vout_low = 1'b0;
  logic       over_temp = 1'b0, en_pin = 1'b0, txd_pin = 1'b0, wake_det = 1'b0;
  logic       reg_en, rst_out_n;
  logic [1:0] lin_mode;
  logic [2:0] mode_code;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  // microsecond tick: every second clock
  always @(posedge clk) us_tick <= ~us_tick;

  pwr_mode_seq i_pwr_mode_seq (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
    .sup_above_hi(sup_above_hi), .sup_below_lo(sup_below_lo),
    .vout_low(vout_low), .over_temp(over_temp), .en_pin(en_pin),
    .txd_pin(txd_pin), .wake_det(wake_det),
    .reg_en(reg_en), .rst_out_n(rst_out_n),
    .lin_mode(lin_mode), .mode_code(mode_code)
  );

  // row: {hi,lo,uv,ot,en,txd,wake}, wait cycles, mode, reg_en, rst_out_n, lin, req
  // mode_code is compared on every row (R12 encoding)
  localparam int NROW = 24;
  localparam logic [33:0] TBL [NROW] = '{
    {7'b0100000, 16'd4,     3'd0, 1'b0, 1'b0, 2'd0, 4'd2 },  // R2
    {7'b1001000, 16'd4,     3'd0, 1'b0, 1'b0, 2'd0, 4'd3 },  // R3 hot blocks exit
    {7'b1010100, 16'd10,    3'd1, 1'b1, 1'b0, 2'd1, 4'd3 },  // R3
    {7'b1010100, 16'd10020, 3'd1, 1'b1, 1'b0, 2'd1, 4'd4 },  // R4 uv holds Reset
    {7'b1000100, 16'd6,     3'd2, 1'b1, 1'b1, 2'd2, 4'd5 },  // R5
    {7'b1000010, 16'd6,     3'd2, 1'b1, 1'b1, 2'd1, 4'd6 },  // R6 pending
    {7'b1000010, 16'd100,   3'd3, 1'b1, 1'b1, 2'd1, 4'd6 },  // R6 Standby
    {7'b1000100, 16'd20,    3'd3, 1'b1, 1'b1, 2'd1, 4'd8 },  // R8 not yet
    {7'b1000100, 16'd40,    3'd2, 1'b1, 1'b1, 2'd2, 4'd8 },  // R8
    {7'b1000010, 16'd20,    3'd2, 1'b1, 1'b1, 2'd1, 4'd6 },  // R6
    {7'b1000100, 16'd6,     3'd2, 1'b1, 1'b1, 2'd2, 4'd7 },  // R7
    {7'b1000100, 16'd120,   3'd2, 1'b1, 1'b1, 2'd2, 4'd7 },  // R7
    {7'b1000000, 16'd110,   3'd4, 1'b0, 1'b0, 2'd1, 4'd6 },  // R6 Sleep
    {7'b1000001, 16'd6,     3'd1, 1'b1, 1'b0, 2'd1, 4'd9 },  // R9 wake
    {7'b1000000, 16'd10030, 3'd3, 1'b1, 1'b1, 2'd1, 4'd4 },  // R4 to Standby
    {7'b1010000, 16'd30,    3'd3, 1'b1, 1'b1, 2'd1, 4'd10},  // R10 short dip
    {7'b1000000, 16'd4,     3'd3, 1'b1, 1'b1, 2'd1, 4'd10},  // R10
    {7'b1010000, 16'd70,    3'd1, 1'b1, 1'b0, 2'd1, 4'd10},  // R10 long dip
    {7'b1001000, 16'd6,     3'd5, 1'b0, 1'b0, 2'd1, 4'd11},  // R11
    {7'b1000000, 16'd6,     3'd1, 1'b1, 1'b0, 2'd1, 4'd11},  // R11
    {7'b1000100, 16'd10040, 3'd2, 1'b1, 1'b1, 2'd2, 4'd4 },  // R4 to Normal
    {7'b1000000, 16'd110,   3'd4, 1'b0, 1'b0, 2'd1, 4'd9 },  // R9
    {7'b1000100, 16'd6,     3'd1, 1'b1, 1'b0, 2'd1, 4'd9 },  // R9 EN exit
    {7'b1101100, 16'd4,     3'd0, 1'b0, 1'b0, 2'd0, 4'd2 }   // R2 priority
  };

  task automatic check(input int req, input logic [2:0] em, input logic er,
                       input logic es, input logic [1:0] el);
    n_chk++;
    if (mode_code !== em || reg_en !== er || rst_out_n !== es || lin_mode !== el) begin
      n_fail++;
      $display("FAIL R%0d: mode/reg/rst/lin actual=%0d/%0b/%0b/%0d expected=%0d/%0b/%0b/%0d",
               req, mode_code, reg_en, rst_out_n, lin_mode, em, er, es, el);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    check(1, 3'd0, 1'b0, 1'b0, 2'd0);
    rst_n = 1'b1;
    for (int i = 0; i < NROW; i++) begin
      @(negedge clk);
      {sup_above_hi, sup_below_lo, vout_low, over_temp, en_pin, txd_pin, wake_det} = TBL[i][33:27];
      repeat (int'(TBL[i][26:11]) - 1) @(negedge clk);
      check(int'(TBL[i][3:0]), TBL[i][10:8], TBL[i][7], TBL[i][6], TBL[i][5:4]);
    end
    // R1: reset asserted mid-run returns to Shutdown state
    {sup_above_hi, sup_below_lo, vout_low, over_temp, en_pin, txd_pin, wake_det} = 7'b1000100;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(1, 3'd0, 1'b0, 1'b0, 2'd0);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule